// File: doc/BRIEF.md
# Predicted Wear Remap Selector

At the close of each wear-leveling interval, this block walks two per-page tables once. The first table holds per-interval raw write counts and is indexed by physical page. The second holds accumulated effective-write totals and is indexed by device page. From these it picks the candidate pair for a swap. The physical page with the heaviest raw traffic is the source. The target is the device page with the lowest projected wear: its effective-write total plus an extra load. That extra load is the interval length scaled by a weight tied to the page's address group. Device pages nearer the write drivers wear faster for the same write, so their groups carry larger weights. The swap itself and the table updates belong to the surrounding controller.

The block drives one table index per cycle. It reads the raw count, the lifetime count and the current mapping of that index through combinational read ports. When the scan ends, it reports the winning indices for one cycle. It also flags whether a swap is worthwhile. A swap is not worthwhile when the hottest physical page already lives on the least-worn device page.

Top module: `remap_wear_selector`

## Requirements
- R1: After reset, `done` and `pairValid` are 0 until a scan completes.
- R2: The predicted wear of device page d is lifeCnt[d] + floor(w*intervalLen/4). Here w is in quarter units, w = 4 + 2*g, and g is the top two bits of d. With the default 16 pages and 4 groups this gives weights 1.0, 1.5, 2.0 and 2.5.
- R3: `physIdx` is the index with the largest `rawCnt`.
- R4: `devIdx` is the index with the smallest predicted wear.
- R5: Ties in the maximum or the minimum resolve to the lowest index.
- R6: If `start` is sampled at clock edge k, `done` is high only in the cycle after edge k+N (N = NUM_PAGES), for exactly one cycle.
- R7: `pairValid` equals `done` AND (mapDev of the chosen physical page != `devIdx`). When the two are already mapped together, `pairValid` stays 0.
- R8: A `start` pulse during a running scan is ignored: completion time and result are unchanged.
- R9: `rdIdx` is 0 in the cycle after the start edge and advances by one each cycle up to N-1. Table data is read combinationally in the same cycle.
- R10: With full-scale lifetime counts (2^20-1) and the full-scale interval (2^16-1), the comparison produces no overflow. `intervalLen` is held stable during a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| intervalLen | input | 16 | Writes per interval |
| rdIdx | output | 4 | Table read index |
| rawCnt | input | 14 | Raw writes of physical page rdIdx |
| lifeCnt | input | 20 | Effective writes of device page rdIdx |
| mapDev | input | 4 | Device page currently mapped to physical page rdIdx |
| done | output | 1 | One-cycle scan-complete pulse |
| pairValid | output | 1 | A swap of physIdx and devIdx is needed |
| physIdx | output | 4 | Hottest physical page |
| devIdx | output | 4 | Least predicted-wear device page |

## Verification
The winning indices and `pairValid` appear together with `done`, which follows N clock edges after the edge that samples `start`. The index stays at 0 right after that edge and reaches N-1 one cycle before `done`. The bench counts negative edges from the start edge. It samples `done` at N-1, N and N+1 edges, and it reads the indices only in the `done` cycle. A second `start` is injected mid-scan, and the bench verifies that the completion cycle does not move.

// File: rtl/remap_sel_pkg.sv
package remap_sel_pkg;
  typedef struct packed {
    logic scan;   // capture the current table entry
    logic first;  // current entry seeds the running best values
  } selCtl_t;
endpackage

// File: rtl/remap_sel_ctrl.sv
module remap_sel_ctrl
  import remap_sel_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int IDX_W = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic [IDX_W-1:0] rdIdx,
  output selCtl_t          ctl,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} selState_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAGES - 1);

  selState_t stateQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      idxQ   <= '0;
    end else begin
      unique case (stateQ)
        S_IDLE: if (start) begin
          stateQ <= S_SCAN;
          idxQ   <= '0;
        end
        S_SCAN: begin
          if (idxQ == LAST_IDX) stateQ <= S_FIN;
          else                  idxQ   <= idxQ + 1'b1;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.scan  = (stateQ == S_SCAN);
    ctl.first = (stateQ == S_SCAN) && (idxQ == '0);
    done      = (stateQ == S_FIN);
    rdIdx     = idxQ;
  end
endmodule

// File: rtl/remap_sel_dp.sv
module remap_sel_dp
  import remap_sel_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int NUM_GROUPS = 4,
  parameter int RAW_W      = 14,
  parameter int LIFE_W     = 20,
  parameter int INTV_W     = 16,
  parameter int WGT_FRAC   = 2,
  parameter int WGT_BASE   = 4,
  parameter int WGT_STEP   = 2,
  localparam int IDX_W  = $clog2(NUM_PAGES),
  localparam int GRP_W  = $clog2(NUM_GROUPS),
  localparam int WGT_W  = $clog2(WGT_BASE + WGT_STEP * (NUM_GROUPS - 1) + 1),
  localparam int PROD_W = WGT_W + INTV_W,
  localparam int PRED_W = ((LIFE_W > PROD_W - WGT_FRAC) ? LIFE_W : PROD_W - WGT_FRAC) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  selCtl_t           ctl,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [INTV_W-1:0] intervalLen,
  input  logic [RAW_W-1:0]  rawCnt,
  input  logic [LIFE_W-1:0] lifeCnt,
  input  logic [IDX_W-1:0]  mapDev,
  output logic [IDX_W-1:0]  maxPhys,
  output logic [IDX_W-1:0]  maxMap,
  output logic [IDX_W-1:0]  minDev
);
  // Per-group weight table, unsigned fixed point with WGT_FRAC fraction bits.
  logic [WGT_W-1:0] wgtRom [NUM_GROUPS];
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gWgt
    assign wgtRom[g] = WGT_W'(WGT_BASE + WGT_STEP * g);
  end

  logic [GRP_W-1:0]  grpSel;
  logic [WGT_W-1:0]  wgtSel;
  logic [PROD_W-1:0] prod;
  logic [PRED_W-1:0] predCur;

  logic [RAW_W-1:0]  maxRawQ;
  logic [PRED_W-1:0] minPredQ;

  always_comb begin
    grpSel  = rdIdx[IDX_W-1 -: GRP_W];
    wgtSel  = wgtRom[grpSel];
    prod    = PROD_W'(wgtSel) * PROD_W'(intervalLen);
    predCur = PRED_W'(lifeCnt) + PRED_W'(prod >> WGT_FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxRawQ  <= '0;
      minPredQ <= '0;
      maxPhys  <= '0;
      maxMap   <= '0;
      minDev   <= '0;
    end else if (ctl.scan) begin
      if (ctl.first || (rawCnt > maxRawQ)) begin
        maxRawQ <= rawCnt;
        maxPhys <= rdIdx;
        maxMap  <= mapDev;
      end
      if (ctl.first || (predCur < minPredQ)) begin
        minPredQ <= predCur;
        minDev   <= rdIdx;
      end
    end
  end
endmodule

// File: rtl/remap_wear_selector.sv
module remap_wear_selector
  import remap_sel_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int NUM_GROUPS = 4,
  parameter int RAW_W      = 14,
  parameter int LIFE_W     = 20,
  parameter int INTV_W     = 16,
  localparam int IDX_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [INTV_W-1:0] intervalLen,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic [RAW_W-1:0]  rawCnt,
  input  logic [LIFE_W-1:0] lifeCnt,
  input  logic [IDX_W-1:0]  mapDev,
  output logic              done,
  output logic              pairValid,
  output logic [IDX_W-1:0]  physIdx,
  output logic [IDX_W-1:0]  devIdx
);
  selCtl_t ctl;
  logic [IDX_W-1:0] maxMap;

  remap_sel_ctrl #(.NUM_PAGES(NUM_PAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rdIdx(rdIdx), .ctl(ctl), .done(done)
  );

  remap_sel_dp #(
    .NUM_PAGES(NUM_PAGES), .NUM_GROUPS(NUM_GROUPS),
    .RAW_W(RAW_W), .LIFE_W(LIFE_W), .INTV_W(INTV_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdIdx(rdIdx),
    .intervalLen(intervalLen), .rawCnt(rawCnt), .lifeCnt(lifeCnt),
    .mapDev(mapDev), .maxPhys(physIdx), .maxMap(maxMap), .minDev(devIdx)
  );

  assign pairValid = done && (maxMap != devIdx);
endmodule

// File: rtl/remap_sel_chk.sv
module remap_sel_chk #(
  parameter int NUM_PAGES = 16,
  localparam int CNT_W = $clog2(NUM_PAGES + 1) + 1
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic done,
  input logic pairValid
);
  logic             busyT;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyT <= 1'b0;
      cnt   <= '0;
    end else if (!busyT && start) begin
      busyT <= 1'b1;
      cnt   <= '0;
    end else if (busyT) begin
      if (done) busyT <= 1'b0;
      else      cnt   <= cnt + 1'b1;
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6 and R8: completion exactly NUM_PAGES edges after the accepted start
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyT && cnt == CNT_W'(NUM_PAGES)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busyT |-> !done);

  a_r7_pair_with_done: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> done);
endmodule

bind remap_wear_selector remap_sel_chk #(.NUM_PAGES(NUM_PAGES)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .pairValid(pairValid)
);

// File: tb/tb_remap_wear_selector.sv
`timescale 1ns/1ps
module tb_remap_wear_selector;
  localparam int N = 16;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] intervalLen = '0;
  logic [3:0]  rdIdx;
  logic [13:0] rawCnt;
  logic [19:0] lifeCnt;
  logic [3:0]  mapDev;
  logic done, pairValid;
  logic [3:0] physIdx, devIdx;

  logic [13:0] rawTab  [N];
  logic [19:0] lifeTab [N];
  logic [3:0]  mapTab  [N];

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  assign rawCnt  = rawTab[rdIdx];
  assign lifeCnt = lifeTab[rdIdx];
  assign mapDev  = mapTab[rdIdx];

  remap_wear_selector dut (
    .clk(clk), .rstN(rstN), .start(start), .intervalLen(intervalLen),
    .rdIdx(rdIdx), .rawCnt(rawCnt), .lifeCnt(lifeCnt), .mapDev(mapDev),
    .done(done), .pairValid(pairValid), .physIdx(physIdx), .devIdx(devIdx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint predOf(int d, int intv);
    int g = d / (N / G);
    int w = 4 + 2 * g;
    return longint'(lifeTab[d]) + (longint'(w) * intv) / 4;
  endfunction

  function automatic int expPhys();
    int best = 0;
    for (int i = 1; i < N; i++) if (rawTab[i] > rawTab[best]) best = i;
    return best;
  endfunction

  function automatic int expDev(int intv);
    int best = 0;
    for (int i = 1; i < N; i++) if (predOf(i, intv) < predOf(best, intv)) best = i;
    return best;
  endfunction

  // Runs one scan; extraStart injects a start pulse mid-scan (R8).
  task automatic runScan(input int intv, input bit extraStart, input string tag);
    int eP = expPhys();
    int eD = expDev(intv);
    int eV = (int'(mapTab[eP]) != eD) ? 1 : 0;
    intervalLen = 16'(intv);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;            // after start edge k
    chk(rdIdx == 4'd0, "R9 rdIdx first", rdIdx, 0);
    for (int m = 1; m < N; m++) begin
      @(negedge clk);
      if (extraStart && m == 3) start = 1'b1;
      else start = 1'b0;
      if (m == N - 1) begin
        chk(rdIdx == 4'(N - 1), "R9 rdIdx last", rdIdx, N - 1);
        chk(done == 1'b0, {"R6 done early ", tag}, done, 0);
      end
    end
    @(negedge clk);                          // after edge k+N
    start = 1'b0;
    chk(done == 1'b1, {"R6/R8 done due ", tag}, done, 1);
    chk(physIdx == 4'(eP), {"R3/R5 physIdx ", tag}, physIdx, eP);
    chk(devIdx == 4'(eD), {"R2/R4/R5 devIdx ", tag}, devIdx, eD);
    chk(pairValid == 1'(eV), {"R7 pairValid ", tag}, pairValid, eV);
    @(negedge clk);
    chk(done == 1'b0, {"R6 done pulse ", tag}, done, 0);
    chk(pairValid == 1'b0, {"R7 pairValid low ", tag}, pairValid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      rawTab[i] = '0; lifeTab[i] = '0; mapTab[i] = 4'(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(pairValid == 1'b0, "R1 pairValid reset", pairValid, 0);

    // R5/R7: all equal, identity map: picks index 0 twice, no remap
    runScan(0, 1'b0, "allzero");

    // R2: weight decides against lower lifetime in a hot group
    for (int i = 0; i < N; i++) begin lifeTab[i] = 20'd50000; rawTab[i] = 14'(i); end
    lifeTab[2] = 20'd2000; lifeTab[12] = 20'd1000;
    runScan(1000, 1'b0, "weight1000");     // dev 2: 3000 vs dev 12: 3500
    runScan(0, 1'b0, "weight0");           // dev 12 wins

    // R5 tie on raw max
    for (int i = 0; i < N; i++) rawTab[i] = 14'd7;
    rawTab[5] = 14'd900; rawTab[9] = 14'd900;
    runScan(300, 1'b0, "rawtie");

    // R10 full-scale values
    for (int i = 0; i < N; i++) lifeTab[i] = 20'hFFFFF;
    lifeTab[13] = 20'hFFFF0;
    runScan(65535, 1'b0, "fullscale");

    // R7: hottest page already on least-worn device page
    mapTab[expPhys()] = 4'(expDev(65535));
    runScan(65535, 1'b0, "mapped");

    // R8: start during scan ignored
    runScan(65535, 1'b1, "restart");

    // Random tables
    for (int t = 0; t < 20; t++) begin
      int intv = int'($urandom_range(0, 65535));
      for (int i = 0; i < N; i++) begin
        rawTab[i]  = 14'($urandom_range(0, (t % 2) ? 15 : 16383));
        lifeTab[i] = 20'($urandom_range(0, 1048575));
        mapTab[i]  = 4'($urandom_range(0, N - 1));
      end
      if (t % 4 == 0) mapTab[expPhys()] = 4'(expDev(intv));
      runScan(intv, (t % 5 == 1), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule